// File: doc/BRIEF.md
# Programmable Synthesizer Divider Chain

This block holds the digital dividers that sit around a frequency-synthesis loop. A fixed prescaler slows the oscillator clock by sixteen to form the phase-comparison reference. A programmable feedback counter, loaded with a 9-bit value M, runs on the loop's controlled clock. A divide-by-2 toggle stage follows that counter, so the feedback clock runs at the controlled clock divided by 2M and has an even duty cycle. A post-divider also runs on the controlled clock and produces the output clock. A 2-bit code selects its ratio. The code mapping is not monotonic: codes 00, 01 and 10 select divide-by-2, 4 and 8, and code 11 selects divide-by-1.

The phase comparator, the oscillator and the analog filter are outside the block. In a closed loop, the controlled clock settles at M times twice the reference rate, so it runs at the crystal frequency times 2M/16. M values from 125 to 350 keep a 16 MHz crystal inside the lock window. The counter itself accepts any M from 1 to 511.

The post-divider is a three-state machine. PD_IDLE is the reset state. It leaves on the first controlled-clock edge: to PD_DIV when the code is a divide code, or to PD_BYP when the code is 11. In PD_DIV, a half-period counter toggles the divided clock on each terminal count. The code is adopted only at the terminal count that ends a high phase. At that point the machine reloads for the new ratio and stays in PD_DIV, or moves to PD_BYP if the new code is 11. In PD_BYP, the controlled clock goes straight to the output. The select register changes only on a falling edge, while both clock sources are low. The machine returns to PD_DIV on any cycle in which the code is no longer 11.

Top module: `synth_div_chain`

## Requirements
- R1: `ref_div_out` stays high for 8 and low for 8 `ref_clk` cycles (the prescale ratio 16, split evenly).
- R2: Each high phase and each low phase of `fb_clk_out` lasts exactly `m_value` `vco_clk` cycles, for any `m_value` from 1 to 511. This includes the lock window 125 to 350.
- R3: A new `m_value` is loaded only when the feedback counter reaches zero. While the value changes, every phase of `fb_clk_out` lasts between the old and the new M. After that, every phase lasts the new M.
- R4: `n_code` 00, 01 and 10 divide `vco_clk` by 2, 4 and 8. Each high phase and each low phase of `out_clk` lasts half the ratio.
- R5: With `n_code` 11, `out_clk` is high while `vco_clk` is high and low while it is low.
- R6: In divide mode, a new `n_code` is adopted only at the falling edge of `out_clk` that closes a period. In bypass, it is adopted on any `vco_clk` cycle. No phase of `out_clk` during a change is shorter than the shorter half-period of the two settings (half a `vco_clk` cycle for bypass). No phase is longer than the longer one.
- R7: While `rst_n` is low, `ref_div_out`, `fb_clk_out` and `out_clk` are all low.
- R8: After `rst_n` rises, all counters start from zero:
  - `fb_clk_out` rises on the first `vco_clk` rising edge.
  - `out_clk` with code 00 rises on the second `vco_clk` rising edge.
  - `ref_div_out` rises on the eighth `ref_clk` rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Oscillator clock that feeds the reference prescaler |
| vco_clk | input | 1 | Loop-controlled clock that feeds the feedback and output dividers |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_value | input | 9 | Feedback division value M |
| n_code | input | 2 | Output ratio code: 00=/2, 01=/4, 10=/8, 11=/1 |
| ref_div_out | output | 1 | Reference clock divided by 16 |
| fb_clk_out | output | 1 | Controlled clock divided by 2M, even duty |
| out_clk | output | 1 | Controlled clock divided by the selected ratio |

## Verification
The bench builds the block with its default parameters: a prescale ratio of 16 and a 9-bit M. With these values the whole M field can be reached, including the lock-window edges 125 and 350 and the extremes 1 and 511, within the cycle budget. All four output codes are exercised, including every move into and out of the bypass path. Each transition is scored as a run of phase lengths bounded by the old and new ratios, so a short pulse at a switch point shows up as a run that falls outside those bounds.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int NCODE_W = 2;
    localparam int HALF_W  = 3;

    localparam logic [NCODE_W-1:0] CODE_BYPASS = 2'b11;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_DIV  = 2'd1,
        PD_BYP  = 2'd2
    } pd_state_t;

    // Half-period length in controlled-clock cycles for each divide code
    function automatic logic [HALF_W-1:0] half_cycles(input logic [NCODE_W-1:0] code);
        logic [HALF_W-1:0] h;
        case (code)
            2'b00:   h = 3'd1;
            2'b01:   h = 3'd2;
            2'b10:   h = 3'd4;
            default: h = 3'd0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/sdc_ref_prescale.sv
module sdc_ref_prescale #(
    parameter int PRE_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic clk_div
);
    localparam int CW   = $clog2(PRE_DIV);
    localparam int HALF = PRE_DIV / 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          div_q;

    always_comb begin
        cnt_nxt = (cnt_q == CW'(PRE_DIV - 1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            div_q <= (cnt_nxt >= CW'(HALF));
        end
    end

    assign clk_div = div_q;

    // The divided level may only move at the midpoint or at the wrap
    assert_ref_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> (cnt_q == CW'(HALF) || cnt_q == '0));

endmodule

// File: rtl/sdc_fb_div.sv
module sdc_fb_div #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_value,
    output logic           fb_clk
);
    logic [M_W-1:0] cnt_q;
    logic           tc;
    logic           tog_q;

    // Terminal count of the down-counter
    assign tc = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (tc) begin
            cnt_q <= m_value - 1'b1;
            tog_q <= ~tog_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign fb_clk = tog_q;

    assert_fb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> $stable(tog_q));

    // A mid-count change of M must not disturb the running count
    assert_fb_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdc_post_div.sv
module sdc_post_div (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] n_code,
    output logic       clk_out
);
    import sdc_pkg::*;

    pd_state_t            state_q;
    pd_state_t            state_nxt;
    logic [HALF_W-1:0]    cnt_q;
    logic [HALF_W-1:0]    cnt_nxt;
    logic [NCODE_W-1:0]   act_code_q;
    logic [NCODE_W-1:0]   act_nxt;
    logic                 div_q;
    logic                 div_nxt;
    logic                 byp_q;

    // Next-state and datapath decisions
    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        div_nxt   = div_q;
        act_nxt   = act_code_q;
        unique case (state_q)
            PD_IDLE: begin
                act_nxt = n_code;
                if (n_code == CODE_BYPASS) begin
                    state_nxt = PD_BYP;
                end else begin
                    state_nxt = PD_DIV;
                    cnt_nxt   = half_cycles(n_code) - 3'd1;
                end
            end
            PD_DIV: begin
                if (cnt_q != '0) begin
                    cnt_nxt = cnt_q - 3'd1;
                end else if (!div_q) begin
                    div_nxt = 1'b1;
                    cnt_nxt = half_cycles(act_code_q) - 3'd1;
                end else begin
                    div_nxt = 1'b0;
                    act_nxt = n_code;
                    if (n_code == CODE_BYPASS) begin
                        state_nxt = PD_BYP;
                    end else begin
                        cnt_nxt = half_cycles(n_code) - 3'd1;
                    end
                end
            end
            PD_BYP: begin
                if (n_code != CODE_BYPASS) begin
                    state_nxt = PD_DIV;
                    act_nxt   = n_code;
                    cnt_nxt   = half_cycles(n_code) - 3'd1;
                    div_nxt   = 1'b0;
                end
            end
            default: begin
                state_nxt = PD_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PD_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Output-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            div_q      <= 1'b0;
            act_code_q <= '0;
        end else begin
            cnt_q      <= cnt_nxt;
            div_q      <= div_nxt;
            act_code_q <= act_nxt;
        end
    end

    // Source select moves only while the controlled clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else begin
            byp_q <= (state_q == PD_BYP);
        end
    end

    assign clk_out = byp_q ? clk : div_q;

    assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_DIV && cnt_q != '0) |=> $stable(div_q));

    assert_byp_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_BYP) |-> (act_code_q == CODE_BYPASS));

    assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_DIV && !(cnt_q == '0 && div_q)) |=> $stable(act_code_q));

    assert_byp_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_BYP) |-> !div_q);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R7: assert (clk_out == 1'b0);
        end
    end

endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain #(
    parameter int PRE_DIV = 16,
    parameter int M_W     = 9
) (
    input  logic           ref_clk,
    input  logic           vco_clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_value,
    input  logic [1:0]     n_code,
    output logic           ref_div_out,
    output logic           fb_clk_out,
    output logic           out_clk
);

    sdc_ref_prescale #(
        .PRE_DIV (PRE_DIV)
    ) u_ref (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .clk_div (ref_div_out)
    );

    sdc_fb_div #(
        .M_W (M_W)
    ) u_fb (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .m_value (m_value),
        .fb_clk  (fb_clk_out)
    );

    sdc_post_div u_post (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .n_code  (n_code),
        .clk_out (out_clk)
    );

endmodule

// File: tb/synth_div_chain_test.sv
module synth_div_chain_test;

    localparam int VCO_HALF   = 5;
    localparam int REF_HALF   = 8;
    localparam int WD_CYCLES  = 150000;

    logic       ref_clk;
    logic       vco_clk;
    logic       rst_n;
    logic [8:0] m_value;
    logic [1:0] n_code;
    logic       ref_div_out;
    logic       fb_clk_out;
    logic       out_clk;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Scoreboard queues: channel 0 = reference, 1 = feedback, 2 = output
    int    ref_lo[$], ref_hi[$], fb_lo[$], fb_hi[$], out_lo[$], out_hi[$];
    string ref_rq[$], fb_rq[$], out_rq[$];
    bit    ref_skip, fb_skip, out_skip;
    logic  prev_v [3];
    int    run_len [3];

    synth_div_chain uut (
        .ref_clk     (ref_clk),
        .vco_clk     (vco_clk),
        .rst_n       (rst_n),
        .m_value     (m_value),
        .n_code      (n_code),
        .ref_div_out (ref_div_out),
        .fb_clk_out  (fb_clk_out),
        .out_clk     (out_clk)
    );

    initial begin
        vco_clk = 1'b0;
        forever #(VCO_HALF) vco_clk = ~vco_clk;
    end

    initial begin
        ref_clk = 1'b0;
        #3;
        forever #(REF_HALF) ref_clk = ~ref_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d at %0t", req, act, lo, hi, $time);
        end
    endtask

    task automatic score(input int ch, input int run);
        int lo = 0, hi = 0;
        string rq = "";
        bit have = 0;
        case (ch)
            0: if (ref_lo.size() > 0) begin
                   if (ref_skip) ref_skip = 0;
                   else begin lo = ref_lo.pop_front(); hi = ref_hi.pop_front(); rq = ref_rq.pop_front(); have = 1; end
               end
            1: if (fb_lo.size() > 0) begin
                   if (fb_skip) fb_skip = 0;
                   else begin lo = fb_lo.pop_front(); hi = fb_hi.pop_front(); rq = fb_rq.pop_front(); have = 1; end
               end
            default: if (out_lo.size() > 0) begin
                   if (out_skip) out_skip = 0;
                   else begin lo = out_lo.pop_front(); hi = out_hi.pop_front(); rq = out_rq.pop_front(); have = 1; end
               end
        endcase
        if (have) check(run >= lo && run <= hi, rq, run, lo, hi);
    endtask

    task automatic track(input int ch, input logic v);
        if (!rst_n) begin
            prev_v[ch]  = v;
            run_len[ch] = 0;
        end else if (v !== prev_v[ch]) begin
            score(ch, run_len[ch]);
            prev_v[ch]  = v;
            run_len[ch] = 1;
        end else begin
            run_len[ch]++;
        end
    endtask

    // Driver side: expected phase lengths, first completed run discarded
    task automatic push(input int ch, input int lo, input int hi, input int count, input string req);
        for (int i = 0; i < count; i++) begin
            case (ch)
                0: begin ref_lo.push_back(lo); ref_hi.push_back(hi); ref_rq.push_back(req); end
                1: begin fb_lo.push_back(lo); fb_hi.push_back(hi); fb_rq.push_back(req); end
                default: begin out_lo.push_back(lo); out_hi.push_back(hi); out_rq.push_back(req); end
            endcase
        end
        case (ch)
            0: ref_skip = 1;
            1: fb_skip = 1;
            default: out_skip = 1;
        endcase
    endtask

    task automatic wait_empty(input int ch);
        forever begin
            if (ch == 0 && ref_lo.size() == 0) break;
            if (ch == 1 && fb_lo.size() == 0) break;
            if (ch == 2 && out_lo.size() == 0) break;
            @(posedge vco_clk);
        end
    endtask

    // Output phase length in half-cycle samples
    function automatic int out_len(input logic [1:0] c);
        case (c)
            2'b00: return 2;
            2'b01: return 4;
            2'b10: return 8;
            default: return 1;
        endcase
    endfunction

    // Monitors
    initial begin : mon_ref
        forever begin
            @(posedge ref_clk);
            #2;
            track(0, ref_div_out);
        end
    end

    initial begin : mon_vco
        forever begin
            @(posedge vco_clk);
            #2;
            track(1, fb_clk_out);
            track(2, out_clk);
            #5;
            track(2, out_clk);
        end
    end

    task automatic fb_step(input int new_m, input int trans, input int exact);
        int cur = int'(m_value);
        @(posedge vco_clk); #4;
        push(1, (cur < new_m) ? cur : new_m, (cur > new_m) ? cur : new_m, trans, "R3");
        m_value = 9'(new_m);
        wait_empty(1);
        @(posedge vco_clk); #4;
        push(1, new_m, new_m, exact, "R2");
        wait_empty(1);
    endtask

    task automatic out_step(input logic [1:0] code, input int exact, input string req);
        int a = out_len(n_code);
        int b = out_len(code);
        @(posedge vco_clk); #4;
        push(2, (a < b) ? a : b, (a > b) ? a : b, 4, "R6");
        n_code = code;
        wait_empty(2);
        @(posedge vco_clk); #4;
        push(2, b, b, exact, req);
        wait_empty(2);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge vco_clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (R1..R8 run): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        rst_n   = 1'b0;
        m_value = 9'd125;
        n_code  = 2'b00;
        repeat (4) @(posedge vco_clk);
        #2;
        check(ref_div_out == 1'b0, "R7 ref", int'(ref_div_out), 0, 0);
        check(fb_clk_out == 1'b0, "R7 fb", int'(fb_clk_out), 0, 0);
        check(out_clk == 1'b0, "R7 out high phase", int'(out_clk), 0, 0);
        #5;
        check(out_clk == 1'b0, "R7 out low phase", int'(out_clk), 0, 0);

        @(negedge vco_clk);
        rst_n = 1'b1;
        fork
            begin
                @(posedge vco_clk); #2;
                check(fb_clk_out == 1'b1, "R8 fb first edge", int'(fb_clk_out), 1, 1);
                check(out_clk == 1'b0, "R8 out first edge", int'(out_clk), 0, 0);
                @(posedge vco_clk); #2;
                check(out_clk == 1'b1, "R8 out second edge", int'(out_clk), 1, 1);
            end
            begin
                repeat (7) @(posedge ref_clk); #2;
                check(ref_div_out == 1'b0, "R8 ref edge7", int'(ref_div_out), 0, 0);
                @(posedge ref_clk); #2;
                check(ref_div_out == 1'b1, "R8 ref edge8", int'(ref_div_out), 1, 1);
            end
        join

        // R1: prescaler phases
        push(0, 8, 8, 4, "R1");
        wait_empty(0);

        // R4: code 00 after reset
        @(posedge vco_clk); #4;
        push(2, 2, 2, 6, "R4 /2");
        wait_empty(2);

        // R4, R5, R6: every code and the bypass moves
        out_step(2'b01, 6, "R4 /4");
        out_step(2'b10, 4, "R4 /8");
        out_step(2'b11, 8, "R5 bypass");
        for (int i = 0; i < 2; i++) begin
            @(posedge vco_clk); #2;
            check(out_clk == 1'b1, "R5 follows high", int'(out_clk), 1, 1);
            #5;
            check(out_clk == 1'b0, "R5 follows low", int'(out_clk), 0, 0);
        end
        out_step(2'b00, 6, "R4 /2 after bypass");
        out_step(2'b11, 6, "R5 bypass again");
        out_step(2'b10, 4, "R4 /8 after bypass");
        out_step(2'b01, 6, "R4 /4 down");

        // R2, R3: feedback divider at lock-window edges and extremes
        @(posedge vco_clk); #4;
        push(1, 125, 125, 3, "R2 M=125");
        wait_empty(1);
        fb_step(350, 3, 3);
        fb_step(1, 3, 6);
        fb_step(511, 3, 2);
        fb_step(2, 3, 4);
        fb_step(125, 3, 2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule